// File: doc/BRIEF.md
# Two-Sample Averaging Filter with Four-Phase Handshakes

This block is a streaming recursive filter. It takes unsigned samples one at a time over a four-phase request/acknowledge input channel. For each sample it sends out, on a second four-phase channel, the mean of that sample and the sample before it. The mean is rounded down, so the result is floor((current + previous) / 2). Before the first sample, the previous value counts as zero.

Inside, a sequencer runs nested handshakes, all modelled in a single clock domain. A capture register takes the incoming sample. An adder with a fixed delay answers its own request/acknowledge pair after a set number of cycles. An output register holds the result for the whole time the output request is high. A history register takes the current sample only once the output handshake has returned to zero. Every step waits for the one before it, so at most one sample is in flight at a time.

Top module: `avg2_filter`

## Requirements
- R1: After reset, `in_ack` and `out_req` are low and `out_data` is zero.
- R2: The first result after reset is `floor(x/2)`, because the stored previous sample starts at zero.
- R3: Each result equals `(x + p) >> 1`, where `x` is the sample just accepted and `p` is the sample accepted before it. The sum is formed at N+1 bits, so the result never wraps; for example, two full-scale inputs give full scale.
- R4: `in_ack` goes high only in the cycle after `in_req` has been seen high. The sample is captured on that same edge, so changing `in_data` after `in_ack` rises has no effect on the result.
- R5: `in_ack` falls one cycle after `in_req` is seen low. No new sample is acknowledged until the output handshake has fully returned to zero.
- R6: `out_req` goes high exactly DELAY+3 clock cycles after `in_ack` falls. DELAY is the adder's matched delay in cycles.
- R7: Once `out_req` is high, it stays high and `out_data` stays unchanged until `out_ack` is seen high.
- R8: The history value takes the current sample only after `out_ack` has returned low. The next result therefore uses the sample just averaged.
- R9: While `in_req` stays low, neither `in_ack` nor `out_req` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_req | input | 1 | Input request: high while `in_data` holds a valid sample |
| in_ack | output | 1 | Input acknowledge: high once the sample is captured |
| in_data | input | N | Input sample, unsigned |
| out_req | output | 1 | Output request: high while `out_data` is valid |
| out_ack | input | 1 | Output acknowledge from the consumer |
| out_data | output | N | Averaged result |

## Verification
A history register that updates too early or too late gives a wrong value on `out_data` from the very next result onward. A result that is too high or too low shows on the same handshake. Feeding every ordered pair of sample values catches both kinds of fault, including the carry at full scale. A sequencer that skips a step or waits in the wrong place changes the DELAY+3 count from input release to output request, which is measured on every sample. It can also let `in_ack` rise while the previous output is still pending, which the bench probes one cycle after the output handshake ends.

// File: rtl/avg2_pkg.sv
package avg2_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_INACK  = 3'd1,
        ST_ADD    = 3'd2,
        ST_ADDRST = 3'd3,
        ST_OUT    = 3'd4,
        ST_OUTRST = 3'd5
    } avg2_state_e;

    typedef struct packed {
        avg2_state_e st;
        logic        in_ack;
        logic        add_req;
        logic        out_req;
    } avg2_ctrl_s;

    localparam avg2_ctrl_s CTRL_RESET = '{st: ST_IDLE, in_ack: 1'b0,
                                          add_req: 1'b0, out_req: 1'b0};

endpackage

// File: rtl/avg2_reg.sv
module avg2_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (en) val_d = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign q = val_q;
endmodule

// File: rtl/avg2_adder.sv
module avg2_adder #(
    parameter int N     = 8,
    parameter int DELAY = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    output logic         ack,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N:0]   sum
);
    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DELAY - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ack;
    } add_s;

    add_s add_d, add_q;

    always_comb begin
        add_d = add_q;
        if (req && !add_q.ack) begin
            if (add_q.cnt == CNT_LAST) add_d.ack = 1'b1;
            else                       add_d.cnt = add_q.cnt + 1'b1;
        end else if (!req) begin
            add_d.ack = 1'b0;
            add_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) add_q <= '0;
        else        add_q <= add_d;
    end

    assign ack = add_q.ack;
    assign sum = {1'b0, a} + {1'b0, b};

    // R6: completion is only signalled while a request is pending
    a_r6_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req));
    // R6: completion holds until the request is withdrawn
    a_r6_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack) && $past(req)) |-> ack);
endmodule

// File: rtl/avg2_ctrl.sv
module avg2_ctrl
    import avg2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_req,
    output logic in_ack,
    input  logic out_ack,
    output logic out_req,
    output logic add_req,
    input  logic add_ack,
    output logic x_en,
    output logic y_en,
    output logic o_en
);
    avg2_ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        x_en  = 1'b0;
        y_en  = 1'b0;
        o_en  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: if (in_req) begin
                x_en         = 1'b1;
                ctl_d.in_ack = 1'b1;
                ctl_d.st     = ST_INACK;
            end
            ST_INACK: if (!in_req) begin
                ctl_d.in_ack  = 1'b0;
                ctl_d.add_req = 1'b1;
                ctl_d.st      = ST_ADD;
            end
            ST_ADD: if (add_ack) begin
                o_en          = 1'b1;
                ctl_d.add_req = 1'b0;
                ctl_d.st      = ST_ADDRST;
            end
            ST_ADDRST: if (!add_ack) begin
                ctl_d.out_req = 1'b1;
                ctl_d.st      = ST_OUT;
            end
            ST_OUT: if (out_ack) begin
                ctl_d.out_req = 1'b0;
                ctl_d.st      = ST_OUTRST;
            end
            ST_OUTRST: if (!out_ack) begin
                y_en     = 1'b1;
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d = CTRL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTRL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign in_ack  = ctl_q.in_ack;
    assign out_req = ctl_q.out_req;
    assign add_req = ctl_q.add_req;

    a_r4_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> $past(in_req));
    a_r5_no_ack_with_output: assert property (@(posedge clk) disable iff (!rst_n)
        out_req |-> !in_ack);
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_req) && !$past(out_ack)) |-> out_req);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req) |-> !in_ack && !add_req);
endmodule

// File: rtl/avg2_filter.sv
module avg2_filter #(
    parameter int N     = 8,
    parameter int DELAY = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_req,
    output logic         in_ack,
    input  logic [N-1:0] in_data,
    output logic         out_req,
    input  logic         out_ack,
    output logic [N-1:0] out_data
);
    localparam int NREG = 2; // 0: current sample, 1: previous sample

    logic           add_req, add_ack;
    logic           x_en, y_en, o_en;
    logic [N:0]     sum;
    logic [N-1:0]   smp_q [NREG];
    logic [N-1:0]   smp_d [NREG];
    logic           smp_en [NREG];

    avg2_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_req  (in_req),
        .in_ack  (in_ack),
        .out_ack (out_ack),
        .out_req (out_req),
        .add_req (add_req),
        .add_ack (add_ack),
        .x_en    (x_en),
        .y_en    (y_en),
        .o_en    (o_en)
    );

    assign smp_d[0]  = in_data;
    assign smp_en[0] = x_en;
    assign smp_d[1]  = smp_q[0];
    assign smp_en[1] = y_en;

    for (genvar g = 0; g < NREG; g++) begin : g_smp
        avg2_reg #(.W(N)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (smp_en[g]),
            .d     (smp_d[g]),
            .q     (smp_q[g])
        );
    end

    avg2_adder #(.N(N), .DELAY(DELAY)) u_add (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (add_req),
        .ack   (add_ack),
        .a     (smp_q[0]),
        .b     (smp_q[1]),
        .sum   (sum)
    );

    avg2_reg #(.W(N)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (o_en),
        .d     (sum[N:1]),
        .q     (out_data)
    );

    a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && $past(out_req)) |-> $stable(out_data));
    a_r8_history_waits: assert property (@(posedge clk) disable iff (!rst_n)
        out_req |-> $stable(smp_q[1]));
    a_r4_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && $past(in_ack)) |-> $stable(smp_q[0]));
endmodule

// File: tb/sim_avg2_filter.sv
module sim_avg2_filter;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int DELAY = 3;
    localparam int MAXV  = (1 << N);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_req = 1'b0;
    logic         in_ack;
    logic [N-1:0] in_data = '0;
    logic         out_req;
    logic         out_ack = 1'b0;
    logic [N-1:0] out_data;

    int total = 0;
    int bad   = 0;
    int prev  = 0;
    bit done  = 1'b0;
    bit first = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    avg2_filter #(.N(N), .DELAY(DELAY)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_req   (in_req),
        .in_ack   (in_ack),
        .in_data  (in_data),
        .out_req  (out_req),
        .out_ack  (out_ack),
        .out_data (out_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input int val, input int hold);
        int cnt;
        int exp;
        int held;
        in_data = N'(val);
        in_req  = 1'b1;
        @(negedge clk);
        if (!first) chk("R5 no ack before history update", int'(in_ack), 0);
        while (!in_ack) @(negedge clk);
        in_data = N'(~val);      // R4: late change must not matter
        in_req  = 1'b0;
        @(negedge clk);
        while (in_ack) @(negedge clk);
        cnt = 0;
        while (!out_req) begin
            @(negedge clk);
            cnt++;
        end
        chk("R6 latency", cnt, DELAY + 3);
        exp = (val + prev) >> 1;
        if (first) chk("R2 first result", int'(out_data), exp);
        else       chk("R3 average (R8 history)", int'(out_data), exp);
        held = int'(out_data);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk("R7 req held", int'(out_req), 1);
            chk("R7 data stable", int'(out_data), held);
        end
        out_ack = 1'b1;
        @(negedge clk);
        while (out_req) @(negedge clk);
        out_ack = 1'b0;
        prev  = val;
        first = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in_ack reset", int'(in_ack), 0);
        chk("R1 out_req reset", int'(out_req), 0);
        chk("R1 out_data reset", int'(out_data), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 idle in_ack", int'(in_ack), 0);
        chk("R9 idle out_req", int'(out_req), 0);
        send(MAXV - 1, 2);
        for (int a = 0; a < MAXV; a++) begin
            for (int b = 0; b < MAXV; b++) begin
                send(a, (a + b) % 3);
                send(b, b % 2);
            end
        end
        send(MAXV - 1, 0);
        send(MAXV - 1, 0);   // R3 full-scale pair, no wrap
        repeat (6) @(negedge clk);
        chk("R9 idle in_ack end", int'(in_ack), 0);
        chk("R9 idle out_req end", int'(out_req), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule